// File: doc/BRIEF.md
# Token Ring Round-Robin Arbiter with Busy and Parked Token Modes

This block shares one resource among a parameterised number of clients. It does so by passing a single token around a ring of identical cells, one cell per client. A client is granted while its cell holds the token and its request line is high. A client that keeps its request keeps the token, and with it the grant, so the grant lasts until the client releases it.

A mode pin selects how an idle token behaves. In busy mode the token steps to the next cell on every clock while its holder is not requesting, even when no client requests. This keeps the expected response short. In parked mode the token stays at the cell of the most recent owner when nobody requests. It starts moving only when some client raises a request, which saves switching activity. A new mode value is accepted only on clocks when no grant is active.

The token always travels in increasing cell index and wraps from the last cell to cell 0. Every waiting client is therefore reached within a bounded number of hops, whatever its position in the ring.

Top module: `token_ring_arbiter`

## Requirements
- R1: After reset the token sits at cell 0, the stored mode is parked, and no grant is active until a request arrives.
- R2: `gnt_o[i]` is high in exactly those cycles in which cell i holds the token and `req_i[i]` is high. The grant follows the request within the same cycle, with no register stage between them.
- R3: At most one bit of `gnt_o` is high in any cycle, and exactly one cell holds the token at all times.
- R4: While the token holder keeps its request high, the token stays at its cell on every clock, so its grant is held until the request falls.
- R5: In busy mode (stored mode 1), a holder whose request is low passes the token to cell (i+1) mod N on the next clock, even when no client requests.
- R6: In parked mode (stored mode 0), with no request from any client, the token stays where it is.
- R7: In parked mode, when some client requests and the holder does not, the token advances one cell per clock in increasing index order until it reaches a requesting cell.
- R8: The mode pin (`busy_mode_i`: 1 means busy, 0 means parked) is stored on a clock edge only if no grant is active in that cycle. Otherwise the stored mode keeps its value. The stored mode governs token movement from the following cycle on.
- R9: A client that holds its request until granted receives a grant within N*(L+1) cycles, provided every other client holds its grant for at most L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| busy_mode_i | input | 1 | Mode request: 1 for a rotating token, 0 for a parked token |
| req_i | input | NUM_CLIENTS | Per-client request, held high for as long as the resource is needed |
| gnt_o | output | NUM_CLIENTS | Per-client grant, at most one bit high |

## Verification
A wrong token position shows up at the ports in the first cycle in which a request meets the token. With all clients requesting, it shows up at once. A lost or duplicated token shows up as a grant missing for a whole wait, or as two grant bits high together. A mode register that updates during a grant shows up one cycle after the release, as a token that moves when it should stay, or stays when it should move. The bench compares every cycle against a cycle-exact model of the token and the stored mode, so such faults are seen in the cycle they reach `gnt_o`.

// File: rtl/token_ring_pkg.sv
package token_ring_pkg;

  typedef enum logic {
    MODE_PARKED = 1'b0,
    MODE_BUSY   = 1'b1
  } ring_mode_e;

endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ring_mode_reg.sv
module ring_mode_reg
  import token_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_pin_i,
  input  logic       any_gnt_i,
  output ring_mode_e mode_o
);

  ring_mode_e mode_q;
  ring_mode_e mode_d;
  logic       mode_en;

  always_comb begin
    mode_en = ~any_gnt_i;
    mode_d  = mode_pin_i ? MODE_BUSY : MODE_PARKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PARKED;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/ring_cell.sv
module ring_cell #(
  parameter logic RESET_TOKEN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic tok_in_i,
  input  logic circulate_i,
  output logic tok_o,
  output logic gnt_o,
  output logic pass_o
);

  logic tok_q;
  logic tok_d;
  logic pass;

  always_comb begin
    pass  = tok_q & ~req_i & circulate_i;
    tok_d = (tok_q & ~pass) | tok_in_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= RESET_TOKEN;
    end else begin
      tok_q <= tok_d;
    end
  end

  assign tok_o  = tok_q;
  assign gnt_o  = tok_q & req_i;
  assign pass_o = pass;

endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter
  import token_ring_pkg::*;
#(
  parameter int NUM_CLIENTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy_mode_i,
  input  logic [NUM_CLIENTS-1:0] req_i,
  output logic [NUM_CLIENTS-1:0] gnt_o
);

  localparam int LAST = NUM_CLIENTS - 1;

  logic                   rst_n_s;
  logic [NUM_CLIENTS-1:0] tok_q;
  logic [NUM_CLIENTS-1:0] pass;
  logic [NUM_CLIENTS-1:0] gnt;
  ring_mode_e             mode_q;
  logic                   any_req;
  logic                   circulate;

  ring_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ring_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mode_pin_i (busy_mode_i),
    .any_gnt_i  (|gnt),
    .mode_o     (mode_q)
  );

  always_comb begin
    any_req   = |req_i;
    circulate = (mode_q == MODE_BUSY) | any_req;
  end

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_cell
    localparam int PREV = (i == 0) ? LAST : i - 1;
    ring_cell #(.RESET_TOKEN(i == 0)) u_cell (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .req_i       (req_i[i]),
      .tok_in_i    (pass[PREV]),
      .circulate_i (circulate),
      .tok_o       (tok_q[i]),
      .gnt_o       (gnt[i]),
      .pass_o      (pass[i])
    );
  end

  assign gnt_o = gnt;

endmodule

// File: rtl/token_ring_arbiter_chk.sv
module token_ring_arbiter_chk
  import token_ring_pkg::*;
#(
  parameter int NUM_CLIENTS = 4
) (
  input logic                   clk,
  input logic                   rst_n_s,
  input logic [NUM_CLIENTS-1:0] req,
  input logic [NUM_CLIENTS-1:0] gnt,
  input logic [NUM_CLIENTS-1:0] tok,
  input ring_mode_e             mode_q
);

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(gnt)); // R3

  AST_SINGLE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(tok) == 1); // R3

  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tok & req) != '0 |=> $stable(tok)); // R4

  AST_TOKEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((mode_q == MODE_BUSY) || (req != '0)) && ((tok & req) == '0)
    |=> tok == {$past(tok[NUM_CLIENTS-2:0]), $past(tok[NUM_CLIENTS-1])}); // R5

  AST_PARKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_PARKED) && (req == '0) |=> $stable(tok)); // R6

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (gnt != '0) |=> $stable(mode_q)); // R8

endmodule

bind token_ring_arbiter token_ring_arbiter_chk #(.NUM_CLIENTS(NUM_CLIENTS)) u_chk (
  .clk     (clk),
  .rst_n_s (rst_n_s),
  .req     (req_i),
  .gnt     (gnt_o),
  .tok     (tok_q),
  .mode_q  (mode_q)
);

// File: tb/token_ring_arbiter_tb.sv
module token_ring_arbiter_tb;

  localparam int N     = 4;
  localparam int HOLDL = 6;
  localparam int BOUND = N * (HOLDL + 1);

  logic         clk;
  logic         rst_n;
  logic         busy_mode;
  logic [N-1:0] req;
  logic [N-1:0] gnt;

  int   checks;
  int   fails;
  bit   done;
  int   exp_tok;
  logic exp_mode;
  int   seed_dummy;

  int   want [N];
  int   held [N];
  int   dur  [N];
  int   waitc[N];

  token_ring_arbiter #(.NUM_CLIENTS(N)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_mode_i (busy_mode),
    .req_i       (req),
    .gnt_o       (gnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int next_tok(int t, logic [N-1:0] r, logic m);
    if (r[t]) return t;
    if (m || (r != '0)) return (t + 1) % N;
    return t;
  endfunction

  function automatic logic [N-1:0] exp_gnt(int t, logic [N-1:0] r);
    logic [N-1:0] oh;
    oh = '0;
    oh[t] = 1'b1;
    return oh & r;
  endfunction

  // Drive one cycle of inputs, compare against the model, advance the model.
  task automatic step(input logic [N-1:0] r, input logic m, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    req       = r;
    busy_mode = m;
    #1;
    e = exp_gnt(exp_tok, r);
    checks++;
    if (gnt !== e) begin
      fails++;
      $display("FAIL %s gnt actual=%b expected=%b", tag, gnt, e);
    end
    if (rst_n) begin
      exp_tok = next_tok(exp_tok, r, exp_mode);
      if (e == '0) exp_mode = m;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    checks     = 0;
    fails      = 0;
    done       = 1'b0;
    exp_tok    = 0;
    exp_mode   = 1'b0;
    seed_dummy = $urandom(32'd1234);
    rst_n      = 1'b0;
    req        = '0;
    busy_mode  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(4'b0000, 1'b0, "R1");

    // R1: token at cell 0 after reset, all clients asking
    step(4'b1111, 1'b0, "R1");
    // R4: holder keeps grant while others wait
    repeat (5) step(4'b1111, 1'b0, "R4");
    // R2: release, grant passes to next requesting cell
    step(4'b1110, 1'b0, "R2");
    step(4'b1110, 1'b0, "R2");
    // R6: parked token does not move when idle
    repeat (6) step(4'b0000, 1'b0, "R6");
    step(4'b1111, 1'b0, "R6");
    step(4'b0000, 1'b0, "R6");
    // R7: parked, lone far requester pulls the token round
    repeat (N + 1) step(4'b0001, 1'b0, "R7");
    step(4'b0000, 1'b0, "R7");
    // R5: busy mode, token rotates with nobody asking
    repeat (7) step(4'b0000, 1'b1, "R5");
    step(4'b1111, 1'b1, "R5");
    step(4'b0000, 1'b1, "R5");
    // R8: mode pin changed during a grant is ignored until release
    repeat (3) step(4'b1111, 1'b1, "R8");
    repeat (3) step(4'b0100, 1'b0, "R8");
    repeat (3) step(4'b0000, 1'b0, "R8");
    step(4'b1111, 1'b0, "R8");
    step(4'b0000, 1'b0, "R8");

    // R9 / R3: random clients with bounded hold times
    for (int i = 0; i < N; i++) begin
      want[i] = 0; held[i] = 0; dur[i] = 1; waitc[i] = 0;
    end
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r;
      logic         m;
      r = '0;
      for (int i = 0; i < N; i++) r[i] = (want[i] != 0);
      m = (($urandom % 16) == 0) ? ~busy_mode : busy_mode;
      step(r, m, "R9");
      checks++;
      if ($countones(gnt) > 1) begin
        fails++;
        $display("FAIL R3 grants actual=%b expected=onehot0", gnt);
      end
      for (int i = 0; i < N; i++) begin
        if (want[i] != 0) begin
          if (gnt[i]) begin
            if (held[i] == 0) begin
              checks++;
              if (waitc[i] + 1 > BOUND) begin
                fails++;
                $display("FAIL R9 wait client %0d actual=%0d expected<=%0d",
                         i, waitc[i] + 1, BOUND);
              end
            end
            held[i]++;
            if (held[i] >= dur[i]) want[i] = 0;
          end else begin
            waitc[i]++;
          end
        end else if (($urandom % 4) == 0) begin
          want[i]  = 1;
          held[i]  = 0;
          waitc[i] = 0;
          dur[i]   = 1 + ($urandom % HOLDL);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule